// File: doc/BRIEF.md
# Configurable UART frame receiver

This block recovers asynchronous serial characters from a single input line. A strobe that pulses sixteen times per bit period paces it. At run time, configuration inputs choose five settings: the number of data bits (5 to 9), the parity rule, the stop-bit length, whether the first data bit is the least or the most significant, and whether the line is inverted. The settings take effect at the next start bit. A falling edge starts a candidate frame. The frame goes on only if the line is still low at the middle of the start bit. Each later bit is then sampled at the middle of its period, counted from that edge.

One frame produces one report, marked by a single-cycle strobe. The report holds the data right-aligned in a 9-bit field. It also carries a parity-error flag with the expected and received parity bit values, an invalid-stop flag, and an overall good-frame flag. The report fields keep their values until the next report. The block is meant to sit behind a pin on a larger design that consumes characters one at a time.

Top module: `uart_frame_rx`

## Requirements
- R1: After reset, frame_valid is low and frame_data, frame_ok, parity_err, parity_expected, parity_actual and stop_err are all zero.
- R2: A low level that has ended before the middle of the start bit (eighth oversampling tick after the falling edge) produces no report, and the receiver waits for a new start edge.
- R3: cfg_bits gives the data width. Values 5 to 9 are used as given, values below 5 act as 5, and values above 9 act as 9. The data is right-aligned in frame_data, and the bits above the width are zero.
- R4: With cfg_msb_first = 0, the first received data bit is bit 0 of the result. With cfg_msb_first = 1, the first received data bit is the most significant bit of the configured width.
- R5: cfg_parity code 1 is odd parity and code 2 is even parity. Odd expects a bit that makes the count of ones in data plus parity odd; even expects a bit that makes it even. A mismatch sets parity_err. parity_expected and parity_actual report the expected bit and the received bit.
- R6: cfg_parity code 3 requires a parity bit of 0 and code 4 requires a parity bit of 1; a mismatch sets parity_err. Code 5 reads the parity slot, never flags an error, and reports the received bit as both expected and actual.
- R7: cfg_parity code 0 (and the unused codes 6 and 7) means no parity slot. The stop period follows the last data bit, parity_err is 0, and both parity value outputs are 0.
- R8: cfg_stop codes 0, 1, 2 and 3 select stop lengths of 0, 0.5, 1 and 1.5 bit times. The stop level is sampled at the middle of the stop period, and a low sample sets stop_err. With length 0, the report follows the last data or parity bit, and stop_err is 0.
- R9: With cfg_invert = 1, the line is complemented before any decoding, so that a low line is idle.
- R10: Each frame gives exactly one frame_valid pulse of one cycle. frame_ok is 1 exactly when neither parity_err nor stop_err is set, and the report fields hold their values between pulses.
- R11: Width, parity mode, bit order and stop length are captured at the start edge. Changes during a frame do not affect that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_line | input | 1 | Serial input line |
| baud16_tick | input | 1 | One-cycle strobe at sixteen times the bit rate |
| cfg_bits | input | 4 | Requested data width |
| cfg_parity | input | 3 | Parity rule code (0 none, 1 odd, 2 even, 3 zero, 4 one, 5 ignore) |
| cfg_stop | input | 2 | Stop length code (0, 0.5, 1, 1.5 bit times) |
| cfg_msb_first | input | 1 | First data bit is the most significant |
| cfg_invert | input | 1 | Complement the line before decoding |
| frame_valid | output | 1 | One-cycle report strobe |
| frame_data | output | 9 | Received data, right-aligned |
| frame_ok | output | 1 | Frame had no parity or stop fault |
| parity_err | output | 1 | Parity bit did not match the rule |
| parity_expected | output | 1 | Parity value the rule required |
| parity_actual | output | 1 | Parity value received |
| stop_err | output | 1 | Stop level sampled low |

## Verification
A parity failure and a bad stop level are judged in different bit slots. Both must still reach the same report cycle, and the good-frame flag must fall for either one. The bench provokes this by sending frames that carry a wrong parity bit and a stop bit held low up to its sampling point, for each stop length. It then checks that a single strobe carries both flags together with the correct expected and received parity values. Random frames mix the two faults independently, so the bench also covers each fault on its own and the case where neither occurs.

// File: rtl/urx_pkg.sv
package urx_pkg;

   typedef enum logic [2:0] {
      PM_NONE   = 3'd0,
      PM_ODD    = 3'd1,
      PM_EVEN   = 3'd2,
      PM_ZERO   = 3'd3,
      PM_ONE    = 3'd4,
      PM_IGNORE = 3'd5
   } par_mode_e;

   typedef enum logic [1:0] {
      SL_ZERO     = 2'd0,
      SL_HALF     = 2'd1,
      SL_ONE      = 2'd2,
      SL_ONE_HALF = 2'd3
   } stop_len_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_PAR,
      ST_STOP,
      ST_TAIL
   } rx_state_e;

   // Unused codes fall back to "no parity slot".
   function automatic par_mode_e decode_par(input logic [2:0] code);
      case (code)
         3'd1:    return PM_ODD;
         3'd2:    return PM_EVEN;
         3'd3:    return PM_ZERO;
         3'd4:    return PM_ONE;
         3'd5:    return PM_IGNORE;
         default: return PM_NONE;
      endcase
   endfunction

   function automatic logic [3:0] clamp_bits(input logic [3:0] req, input logic [3:0] hi);
      if (req < 4'd5) return 4'd5;
      if (req > hi)   return hi;
      return req;
   endfunction

endpackage

// File: rtl/urx_line_sync.sv
module urx_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   input  logic invert_i,
   output logic line_o
);
   // Polarity is fixed before the synchronizer so idle is always 1.
   logic logical;
   assign logical = line_i ^ invert_i;

   generate
      if (STAGES == 0) begin : g_direct
         assign line_o = logical;
      end else begin : g_chain
         logic [STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '1;
            else if (STAGES == 1) chain <= logical;
            else chain <= {chain[STAGES-2:0], logical};
         end
         assign line_o = chain[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/urx_parity_judge.sv
module urx_parity_judge import urx_pkg::*; #(
   parameter int DMAX = 9
) (
   input  par_mode_e       mode,
   input  logic [DMAX-1:0] data,
   input  logic            rx_bit,
   output logic            exp_o,
   output logic            act_o,
   output logic            err_o
);
   logic ones_odd;
   assign ones_odd = ^data;   // upper bits are zero, so the full vector is safe

   always_comb begin
      exp_o = 1'b0;
      act_o = rx_bit;
      err_o = 1'b0;
      case (mode)
         PM_ODD:    begin exp_o = ~ones_odd; err_o = (exp_o != rx_bit); end
         PM_EVEN:   begin exp_o = ones_odd;  err_o = (exp_o != rx_bit); end
         PM_ZERO:   begin exp_o = 1'b0;      err_o = rx_bit; end
         PM_ONE:    begin exp_o = 1'b1;      err_o = ~rx_bit; end
         PM_IGNORE: begin exp_o = rx_bit; end
         default:   begin act_o = 1'b0; end
      endcase
   end
endmodule

// File: rtl/urx_frame_fsm.sv
module urx_frame_fsm import urx_pkg::*; #(
   parameter int OSR  = 16,
   parameter int DMAX = 9
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tick,
   input  logic            line,
   input  logic [3:0]      cfg_bits,
   input  logic [2:0]      cfg_par,
   input  logic [1:0]      cfg_stop,
   input  logic            cfg_msb,
   output logic            fire,
   output logic            stop_bad,
   output logic [DMAX-1:0] aligned,
   output logic            par_now,
   output par_mode_e       pm_q,
   output stop_len_e       sl_q,
   output logic [3:0]      w_q
);
   localparam int MID  = OSR / 2;
   localparam int QTR  = OSR / 4;
   localparam int CMAX = OSR + QTR;
   localparam int CW   = $clog2(CMAX + 1);
   localparam logic [CW-1:0] C_MID_CHK  = CW'(MID - 2);
   localparam logic [CW-1:0] C_BIT_END  = CW'(OSR - 1);
   localparam logic [CW-1:0] C_TAIL_END = CW'(MID - 1);
   localparam logic [3:0]    W_HI       = 4'(DMAX);

   rx_state_e       st;
   logic [CW-1:0]   cnt;
   logic [3:0]      nbit;
   logic [DMAX-1:0] sh, sh_nx;
   logic            msb_q, par_q;
   logic [CW-1:0]   stop_end_cnt;
   logic            bit_end, last_bit, stop_end;

   // Stop sample sits at the middle of the stop period: half a bit past the
   // last sample point plus half the stop length.
   always_comb begin
      case (sl_q)
         SL_HALF:     stop_end_cnt = CW'(MID + QTR - 1);
         SL_ONE_HALF: stop_end_cnt = CW'(OSR + QTR - 1);
         default:     stop_end_cnt = CW'(OSR - 1);
      endcase
   end

   assign bit_end  = tick && (cnt == C_BIT_END);
   assign stop_end = tick && (cnt == stop_end_cnt);
   assign last_bit = (nbit == (w_q - 4'd1));

   always_comb begin
      sh_nx = sh;
      if (st == ST_DATA && bit_end)
         sh_nx = msb_q ? {sh[DMAX-2:0], line} : {line, sh[DMAX-1:1]};
   end

   assign aligned = msb_q ? sh_nx : (sh_nx >> (W_HI - w_q));
   assign par_now = (st == ST_PAR) ? line : par_q;

   always_comb begin
      fire = 1'b0;
      case (st)
         ST_DATA: fire = bit_end && last_bit && (pm_q == PM_NONE) && (sl_q == SL_ZERO);
         ST_PAR:  fire = bit_end && (sl_q == SL_ZERO);
         ST_STOP: fire = stop_end;
         default: fire = 1'b0;
      endcase
   end
   assign stop_bad = (st == ST_STOP) && !line;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= ST_IDLE;
         cnt   <= '0;
         nbit  <= '0;
         sh    <= '0;
         msb_q <= 1'b0;
         par_q <= 1'b0;
         pm_q  <= PM_NONE;
         sl_q  <= SL_ONE;
         w_q   <= 4'd8;
      end else if (tick) begin
         case (st)
            ST_IDLE: begin
               if (!line) begin
                  st    <= ST_START;
                  cnt   <= '0;
                  nbit  <= '0;
                  sh    <= '0;
                  par_q <= 1'b0;
                  msb_q <= cfg_msb;
                  pm_q  <= decode_par(cfg_par);
                  sl_q  <= stop_len_e'(cfg_stop);
                  w_q   <= clamp_bits(cfg_bits, W_HI);
               end
            end
            ST_START: begin
               if (cnt == C_MID_CHK) begin
                  cnt <= '0;
                  st  <= line ? ST_IDLE : ST_DATA;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_DATA: begin
               if (cnt == C_BIT_END) begin
                  sh   <= sh_nx;
                  cnt  <= '0;
                  nbit <= nbit + 4'd1;
                  if (last_bit) begin
                     if (pm_q != PM_NONE)    st <= ST_PAR;
                     else if (sl_q == SL_ZERO) st <= ST_TAIL;
                     else                      st <= ST_STOP;
                  end
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_PAR: begin
               if (cnt == C_BIT_END) begin
                  par_q <= line;
                  cnt   <= '0;
                  st    <= (sl_q == SL_ZERO) ? ST_TAIL : ST_STOP;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_STOP: begin
               if (cnt == stop_end_cnt) begin
                  cnt <= '0;
                  st  <= ST_IDLE;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_TAIL: begin
               // zero stop length: let the last bit run out before rearming
               if (cnt == C_TAIL_END) begin
                  cnt <= '0;
                  st  <= ST_IDLE;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   // R11: captured settings do not move once a frame is under way
   a_r11_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (st != ST_IDLE && $past(st) != ST_IDLE) |-> ($stable(pm_q) && $stable(w_q) && $stable(sl_q) && $stable(msb_q)));

   // R2: data reception is only entered from a confirmed start bit
   a_r2_start_confirmed: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_DATA && $past(st) == ST_START) |-> !$past(line));

   // R3: never counts more data bits than the captured width
   a_r3_bit_count: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_DATA) |-> (nbit < w_q));
endmodule

// File: rtl/urx_report_reg.sv
module urx_report_reg import urx_pkg::*; #(
   parameter int DMAX = 9
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            fire,
   input  logic [DMAX-1:0] data_i,
   input  logic            pexp_i,
   input  logic            pact_i,
   input  logic            perr_i,
   input  logic            stop_bad_i,
   input  par_mode_e       pm_q,
   input  stop_len_e       sl_q,
   input  logic [3:0]      w_q,
   output logic            valid_o,
   output logic [DMAX-1:0] data_o,
   output logic            ok_o,
   output logic            perr_o,
   output logic            pexp_o,
   output logic            pact_o,
   output logic            serr_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_o <= 1'b0;
         data_o  <= '0;
         ok_o    <= 1'b0;
         perr_o  <= 1'b0;
         pexp_o  <= 1'b0;
         pact_o  <= 1'b0;
         serr_o  <= 1'b0;
      end else begin
         valid_o <= fire;
         if (fire) begin
            data_o <= data_i;
            perr_o <= perr_i;
            pexp_o <= pexp_i;
            pact_o <= pact_i;
            serr_o <= stop_bad_i;
            ok_o   <= !(perr_i || stop_bad_i);
         end
      end
   end

   // R10: a report lasts one cycle
   a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |=> !valid_o);

   // R10: report fields only move with a strobe
   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_o |-> ($stable(data_o) && $stable(ok_o) && $stable(serr_o) && $stable(perr_o)));

   // R3: bits above the captured width are zero
   a_r3_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> ((data_o >> w_q) == '0));

   // R7: no parity slot means no parity report
   a_r7_none_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && pm_q == PM_NONE) |-> (!perr_o && !pexp_o && !pact_o));

   // R6: ignore mode never flags and mirrors the received bit
   a_r6_ignore: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && pm_q == PM_IGNORE) |-> (!perr_o && (pexp_o == pact_o)));

   // R8: zero-length stop cannot be judged bad
   a_r8_stop_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && sl_q == SL_ZERO) |-> !serr_o);
endmodule

// File: rtl/uart_frame_rx.sv
module uart_frame_rx import urx_pkg::*; #(
   parameter int OSR         = 16,
   parameter int DMAX        = 9,
   parameter int SYNC_STAGES = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            rx_line,
   input  logic            baud16_tick,
   input  logic [3:0]      cfg_bits,
   input  logic [2:0]      cfg_parity,
   input  logic [1:0]      cfg_stop,
   input  logic            cfg_msb_first,
   input  logic            cfg_invert,
   output logic            frame_valid,
   output logic [DMAX-1:0] frame_data,
   output logic            frame_ok,
   output logic            parity_err,
   output logic            parity_expected,
   output logic            parity_actual,
   output logic            stop_err
);
   if (OSR < 8 || (OSR % 4) != 0) begin : g_bad_osr
      $error("uart_frame_rx: OSR must be a multiple of 4 and at least 8");
   end
   if (DMAX < 5 || DMAX > 15) begin : g_bad_dmax
      $error("uart_frame_rx: DMAX must lie in 5..15");
   end
   if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("uart_frame_rx: SYNC_STAGES must lie in 0..4");
   end

   logic            line_s;
   logic            fire, stop_bad, par_now;
   logic [DMAX-1:0] aligned;
   par_mode_e       pm_q;
   stop_len_e       sl_q;
   logic [3:0]      w_q;
   logic            pexp, pact, perr;

   urx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .line_i(rx_line), .invert_i(cfg_invert), .line_o(line_s)
   );

   urx_frame_fsm #(.OSR(OSR), .DMAX(DMAX)) u_fsm (
      .clk(clk), .rst_n(rst_n), .tick(baud16_tick), .line(line_s),
      .cfg_bits(cfg_bits), .cfg_par(cfg_parity), .cfg_stop(cfg_stop), .cfg_msb(cfg_msb_first),
      .fire(fire), .stop_bad(stop_bad), .aligned(aligned), .par_now(par_now),
      .pm_q(pm_q), .sl_q(sl_q), .w_q(w_q)
   );

   urx_parity_judge #(.DMAX(DMAX)) u_par (
      .mode(pm_q), .data(aligned), .rx_bit(par_now),
      .exp_o(pexp), .act_o(pact), .err_o(perr)
   );

   urx_report_reg #(.DMAX(DMAX)) u_rep (
      .clk(clk), .rst_n(rst_n), .fire(fire), .data_i(aligned),
      .pexp_i(pexp), .pact_i(pact), .perr_i(perr), .stop_bad_i(stop_bad),
      .pm_q(pm_q), .sl_q(sl_q), .w_q(w_q),
      .valid_o(frame_valid), .data_o(frame_data), .ok_o(frame_ok),
      .perr_o(parity_err), .pexp_o(parity_expected), .pact_o(parity_actual),
      .serr_o(stop_err)
   );
endmodule

// File: tb/sim_uart_frame_rx.sv
module sim_uart_frame_rx;
   localparam int OSR = 16;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_line = 1'b1;
   logic       baud16_tick = 1'b0;
   logic [3:0] cfg_bits = 4'd8;
   logic [2:0] cfg_parity = 3'd0;
   logic [1:0] cfg_stop = 2'd2;
   logic       cfg_msb_first = 1'b0;
   logic       cfg_invert = 1'b0;
   logic       frame_valid;
   logic [8:0] frame_data;
   logic       frame_ok, parity_err, parity_expected, parity_actual, stop_err;

   int checks = 0;
   int errors = 0;
   int tick_cnt = 0;
   int nfr = 0;
   logic [8:0] cap_data;
   logic cap_ok, cap_perr, cap_pexp, cap_pact, cap_serr;
   logic [1:0] div = 2'd0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   uart_frame_rx u0 (
      .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .baud16_tick(baud16_tick),
      .cfg_bits(cfg_bits), .cfg_parity(cfg_parity), .cfg_stop(cfg_stop),
      .cfg_msb_first(cfg_msb_first), .cfg_invert(cfg_invert),
      .frame_valid(frame_valid), .frame_data(frame_data), .frame_ok(frame_ok),
      .parity_err(parity_err), .parity_expected(parity_expected),
      .parity_actual(parity_actual), .stop_err(stop_err)
   );

   always @(negedge clk) begin
      div <= div + 2'd1;
      baud16_tick <= (div == 2'd3);
   end

   always @(posedge clk) if (baud16_tick) tick_cnt <= tick_cnt + 1;

   always @(negedge clk) begin
      if (frame_valid) begin
         nfr = nfr + 1;
         cap_data = frame_data;
         cap_ok = frame_ok;
         cap_perr = parity_err;
         cap_pexp = parity_expected;
         cap_pact = parity_actual;
         cap_serr = stop_err;
      end
   end

   task automatic chk(input bit good, input string req, input string what, input int act, input int exp);
      checks++;
      if (!good) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic wait_ticks(input int n);
      int tgt = tick_cnt + n;
      while (tick_cnt < tgt) @(negedge clk);
   endtask

   function automatic int eff_width(input int w);
      if (w < 5) return 5;
      if (w > 9) return 9;
      return w;
   endfunction

   function automatic int eff_mode(input int pm);
      return (pm > 5) ? 0 : pm;
   endfunction

   function automatic logic rule_bit(input int pm, input logic [8:0] d);
      case (pm)
         1: return ~(^d);
         2: return ^d;
         4: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   task automatic send_frame(input logic [8:0] d, input int w, input int pm, input int sc,
                             input bit msb, input bit inv, input bit flip, input bit bad_stop,
                             input bit chg, input string tag);
      int ew, em, stop_ticks;
      logic [8:0] dm;
      logic pb, e_pexp, e_pact, e_perr, e_serr;
      ew = eff_width(w);
      em = eff_mode(pm);
      dm = d & 9'((1 << ew) - 1);
      @(negedge clk);
      cfg_bits = 4'(w);
      cfg_parity = 3'(pm);
      cfg_stop = 2'(sc);
      cfg_msb_first = msb;
      cfg_invert = inv;
      rx_line = 1'b1 ^ inv;
      wait_ticks(2 * OSR);
      nfr = 0;
      rx_line = 1'b0 ^ inv;
      wait_ticks(OSR);
      for (int i = 0; i < ew; i++) begin
         rx_line = (msb ? dm[ew-1-i] : dm[i]) ^ inv;
         if (chg && i == 0) begin
            cfg_bits = (ew == 5) ? 4'd9 : 4'd5;
            cfg_parity = (em == 0) ? 3'd1 : 3'd0;
            cfg_msb_first = ~msb;
            cfg_stop = (sc == 0) ? 2'd2 : 2'd0;
         end
         wait_ticks(OSR);
      end
      pb = 1'b0;
      if (em != 0) begin
         pb = (em == 5) ? 1'($urandom % 2) : (rule_bit(em, dm) ^ flip);
         rx_line = pb ^ inv;
         wait_ticks(OSR);
      end
      stop_ticks = sc * (OSR / 2);
      if (stop_ticks > 0) begin
         if (bad_stop) begin
            rx_line = 1'b0 ^ inv;
            wait_ticks(stop_ticks / 2);
            rx_line = 1'b1 ^ inv;
            wait_ticks(stop_ticks - stop_ticks / 2);
         end else begin
            rx_line = 1'b1 ^ inv;
            wait_ticks(stop_ticks);
         end
      end
      rx_line = 1'b1 ^ inv;
      wait_ticks(2 * OSR);
      case (em)
         0: begin e_pexp = 1'b0; e_pact = 1'b0; e_perr = 1'b0; end
         5: begin e_pexp = pb; e_pact = pb; e_perr = 1'b0; end
         default: begin e_pexp = rule_bit(em, dm); e_pact = pb; e_perr = flip; end
      endcase
      e_serr = bad_stop && (sc != 0);
      chk(nfr == 1, "R10", {tag, " report count"}, nfr, 1);
      chk(cap_data == dm, "R3,R4,R9,R11", {tag, " data"}, cap_data, dm);
      chk(cap_perr == e_perr, "R5,R6,R7", {tag, " parity_err"}, cap_perr, e_perr);
      chk(cap_pexp == e_pexp && cap_pact == e_pact, "R5,R6,R7",
          {tag, " parity exp/act"}, {cap_pexp, cap_pact}, {e_pexp, e_pact});
      chk(cap_serr == e_serr, "R8", {tag, " stop_err"}, cap_serr, e_serr);
      chk(cap_ok == !(e_perr || e_serr), "R10", {tag, " frame_ok"}, cap_ok, !(e_perr || e_serr));
   endtask

   initial begin
      #(20 * 190000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog run did not complete");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5A17));
      repeat (5) @(negedge clk);
      // R1: reset state
      chk(frame_valid == 0 && frame_data == 0, "R1", "reset valid/data", {frame_valid, frame_data}, 0);
      chk({frame_ok, parity_err, parity_expected, parity_actual, stop_err} == 0, "R1", "reset flags",
          {frame_ok, parity_err, parity_expected, parity_actual, stop_err}, 0);
      rst_n = 1'b1;
      wait_ticks(4);

      // R2: short low pulse is rejected
      nfr = 0;
      rx_line = 1'b0;
      wait_ticks(4);
      rx_line = 1'b1;
      wait_ticks(3 * OSR);
      chk(nfr == 0, "R2", "glitch produced report", nfr, 0);

      // directed frames
      send_frame(9'h0A5, 8, 0, 2, 0, 0, 0, 0, 0, "R4 lsb");
      send_frame(9'h0A5, 8, 0, 2, 1, 0, 0, 0, 0, "R4 msb");
      send_frame(9'h1FF, 3, 0, 2, 0, 0, 0, 0, 0, "R3 clamp low");
      send_frame(9'h1C3, 12, 0, 2, 1, 0, 0, 0, 0, "R3 clamp high");
      send_frame(9'h013, 5, 0, 2, 0, 0, 0, 0, 0, "R3 width5");
      send_frame(9'h155, 9, 1, 2, 0, 0, 0, 0, 0, "R5 odd good");
      send_frame(9'h155, 9, 1, 2, 0, 0, 1, 0, 0, "R5 odd bad");
      send_frame(9'h037, 7, 2, 2, 0, 0, 1, 0, 0, "R5 even bad");
      send_frame(9'h037, 7, 2, 2, 0, 0, 0, 0, 0, "R5 even good");
      send_frame(9'h021, 6, 3, 2, 0, 0, 1, 0, 0, "R6 zero bad");
      send_frame(9'h021, 6, 4, 2, 0, 0, 1, 0, 0, "R6 one bad");
      send_frame(9'h0E4, 8, 5, 2, 0, 0, 0, 0, 0, "R6 ignore");
      send_frame(9'h0E4, 8, 7, 2, 0, 0, 0, 0, 0, "R7 unused code");
      for (int s = 0; s < 4; s++) begin
         send_frame(9'h05C, 8, 0, s, 0, 0, 0, 1, 0, "R8 stop bad");
         send_frame(9'h0C5, 8, 2, s, 1, 0, 1, 1, 0, "R8 both faults");
      end
      send_frame(9'h080, 8, 0, 0, 0, 0, 0, 0, 0, "R8 zero stop high msb");
      send_frame(9'h06B, 8, 1, 2, 0, 1, 0, 0, 0, "R9 inverted");
      send_frame(9'h06B, 8, 1, 3, 1, 1, 1, 1, 0, "R9 inverted faults");
      send_frame(9'h0B2, 8, 0, 2, 0, 0, 0, 0, 1, "R11 change mid-frame");
      send_frame(9'h019, 5, 3, 1, 1, 0, 0, 0, 1, "R11 change mid-frame 2");

      // random frames
      for (int k = 0; k < 80; k++) begin
         send_frame(9'($urandom), int'($urandom % 16), int'($urandom % 7), int'($urandom % 4),
                    1'($urandom % 2), 1'($urandom % 2), ($urandom % 4) == 0,
                    ($urandom % 4) == 0, ($urandom % 8) == 0, "random");
      end

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule